// File: doc/BRIEF.md
# Fractional Baud Rate Divider

This block turns a fixed reference clock into a stream of one-cycle baud ticks. The programmed divisor has an integer part and a fraction given in eighths. Each tick period lasts either the integer part or one reference cycle more. A small accumulator decides which periods get the extra cycle, so that over any run of eight periods the average period equals the programmed divisor exactly. The tick paces a serial bit-clock generator. In parallel-port modes it also paces how often a new byte is put on the port. Together these cover rates from a few hundred baud up to a few megabaud.

A divisor is presented on the integer and fraction inputs and captured with a one-cycle load strobe. The first load after reset starts the divider at once. A load that arrives while the divider is running is held until the current period has ended, so no period is ever cut short. An integer part outside the supported range is clamped to the nearest limit.

Top module: `frac_baud_div`

## Requirements
- R1: After reset, `tick` stays low until the first `load` pulse has been sampled, whatever the divisor inputs hold.
- R2: With a fraction code of 0 and integer part n, consecutive ticks are exactly n reference cycles apart.
- R3: With fraction code k (3-bit unsigned, meaning k/8 of a cycle), every period is n or n+1 cycles. A 3-bit accumulator is cleared by reset and has k added to it at the start of each period. When that addition carries out of 3 bits, the period is n+1.
- R4: For a fixed divisor, any eight consecutive tick periods add up to exactly 8n+k reference cycles.
- R5: When the first `load` after reset is sampled on clock edge e, the first tick is high during the cycle that follows edge e+n-1. That makes the first period n cycles, counted from the cycle before edge e.
- R6: A `load` sampled in the middle of a period does not change that period. The new divisor governs the periods that follow the next tick.
- R7: A `load` sampled on the clock edge that ends a tick cycle governs the period that starts at that edge.
- R8: An integer part below 2, including 0, is treated as 2.
- R9: An integer part above 16384 is treated as 16384.
- R10: `tick` is never high in two consecutive cycles.
- R11: Asserting reset while the divider runs stops the ticks and clears the period counter and the accumulator. Ticks resume only after a new `load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_int | input | INT_W (15) | Integer part of the divisor |
| div_frac | input | 3 | Fraction of the divisor in eighths |
| load | input | 1 | One-cycle strobe that captures `div_int` and `div_frac` |
| tick | output | 1 | One-cycle baud tick |

## Verification
The hardest case to reach from the ports is a `load` that lands exactly in a tick cycle. It has to win over the pending path, and it has to take effect one period sooner than a mid-period load. The bench reaches it by starting a short divisor, waiting for an observed tick and counting off exactly one period of negative edges. It then raises `load` during the next tick cycle and expects the new period length immediately after that tick. A companion test raises `load` a few cycles after a tick and expects one more period of the old length. The eight-period sums are taken from a window that does not start at a boundary of the accumulator cycle, so that a dithering pattern that is only correct from zero would show up.

// File: rtl/fbd_pkg.sv
`timescale 1ns/1ps
package fbd_pkg;
    // Fraction resolution: eighths of a reference cycle.
    localparam int FRAC_W    = 3;
    // Defaults for the integer part of the divisor.
    localparam int DEF_INT_W = 15;
    localparam int DEF_MIN   = 2;
    localparam int DEF_MAX   = 16384;

    typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/fbd_load_ctl.sv
`timescale 1ns/1ps
// Divisor capture: clamps the integer part, holds a load until the next
// period boundary and selects the divisor that the new period uses.
module fbd_load_ctl
    import fbd_pkg::*;
#(
    parameter int INT_W   = DEF_INT_W,
    parameter int MIN_DIV = DEF_MIN,
    parameter int MAX_DIV = DEF_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [INT_W-1:0] int_i,
    input  frac_t            frac_i,
    input  logic             tick_i,
    output logic             active_o,
    output logic             bound_o,
    output logic [INT_W-1:0] sel_int_o,
    output frac_t            sel_frac_o
);
    localparam logic [INT_W-1:0] LO = INT_W'(MIN_DIV);
    localparam logic [INT_W-1:0] HI = INT_W'(MAX_DIV);

    typedef struct packed {
        logic             active;
        logic [INT_W-1:0] cur_int;
        frac_t            cur_frac;
        logic             pend_vld;
        logic [INT_W-1:0] pend_int;
        frac_t            pend_frac;
    } ctl_t;

    ctl_t             s_d, s_q;
    logic [INT_W-1:0] clamped;
    logic             bound;
    logic [INT_W-1:0] sel_int;
    frac_t            sel_frac;

    always_comb begin
        if (int_i < LO)
            clamped = LO;
        else if (int_i > HI)
            clamped = HI;
        else
            clamped = int_i;

        // A period boundary is a tick, or the very first load while idle.
        bound = tick_i || (!s_q.active && load_i);

        // A load in the boundary cycle wins over an older pending value.
        if (load_i) begin
            sel_int  = clamped;
            sel_frac = frac_i;
        end else if (s_q.pend_vld) begin
            sel_int  = s_q.pend_int;
            sel_frac = s_q.pend_frac;
        end else begin
            sel_int  = s_q.cur_int;
            sel_frac = s_q.cur_frac;
        end

        s_d = s_q;
        if (bound) begin
            s_d.active   = 1'b1;
            s_d.cur_int  = sel_int;
            s_d.cur_frac = sel_frac;
            s_d.pend_vld = 1'b0;
        end else if (load_i) begin
            s_d.pend_vld  = 1'b1;
            s_d.pend_int  = clamped;
            s_d.pend_frac = frac_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign active_o   = s_q.active;
    assign bound_o    = bound;
    assign sel_int_o  = sel_int;
    assign sel_frac_o = sel_frac;
endmodule

// File: rtl/fbd_dither.sv
`timescale 1ns/1ps
// Fraction accumulator: each period boundary adds the fraction code, and a
// carry out of the top bit stretches that period by one cycle.
module fbd_dither
    import fbd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  frac_t frac_i,
    output logic  carry_o
);
    frac_t             acc_d, acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac_i};
        acc_d = adv_i ? sum[FRAC_W-1:0] : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign carry_o = sum[FRAC_W];
endmodule

// File: rtl/fbd_period_cnt.sv
`timescale 1ns/1ps
// Period counter: loaded with length-1 at each boundary, counts down,
// and flags a tick when it sits at zero while the divider runs.
module fbd_period_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (reload_i)
            cnt_d = len_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tick_o = active_i && (cnt_q == '0);
endmodule

// File: rtl/frac_baud_div.sv
`timescale 1ns/1ps
module frac_baud_div
    import fbd_pkg::*;
#(
    parameter int INT_W   = DEF_INT_W,
    parameter int MIN_DIV = DEF_MIN,
    parameter int MAX_DIV = DEF_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              load,
    output logic              tick
);
    logic             active;
    logic             bound;
    logic [INT_W-1:0] sel_int;
    frac_t            sel_frac;
    logic             carry;
    logic [INT_W-1:0] len;

    fbd_load_ctl #(
        .INT_W  (INT_W),
        .MIN_DIV(MIN_DIV),
        .MAX_DIV(MAX_DIV)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .int_i     (div_int),
        .frac_i    (div_frac),
        .tick_i    (tick),
        .active_o  (active),
        .bound_o   (bound),
        .sel_int_o (sel_int),
        .sel_frac_o(sel_frac)
    );

    fbd_dither u_dith (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (bound),
        .frac_i (sel_frac),
        .carry_o(carry)
    );

    // Length of the period that starts at this boundary.
    assign len = sel_int + {{(INT_W-1){1'b0}}, carry};

    fbd_period_cnt #(
        .CNT_W(INT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .reload_i(bound),
        .len_i   (len),
        .tick_o  (tick)
    );
endmodule

// File: rtl/fbd_checker.sv
`timescale 1ns/1ps
module fbd_checker #(
    parameter int MIN_DIV = 2,
    parameter int MAX_DIV = 16384
) (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic tick
);
    localparam int GAP_W = $clog2(MAX_DIV + 2) + 1;

    logic             seen_load_q;
    logic             had_prev_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_load_q <= 1'b0;
            had_prev_q  <= 1'b0;
            gap_q       <= '0;
        end else begin
            if (load)
                seen_load_q <= 1'b1;
            if (tick) begin
                had_prev_q <= 1'b1;
                gap_q      <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    // Covers R11 as well: reset clears the load history.
    assert_no_tick_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load_q |-> !tick);

    assert_single_cycle_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_min_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && had_prev_q) |-> (gap_q >= GAP_W'(MIN_DIV)));

    assert_max_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && had_prev_q) |-> (gap_q <= GAP_W'(MAX_DIV + 1)));
endmodule

bind frac_baud_div fbd_checker #(
    .MIN_DIV(MIN_DIV),
    .MAX_DIV(MAX_DIV)
) u_fbd_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .tick (tick)
);

// File: tb/frac_baud_div_bench.sv
`timescale 1ns/1ps
module frac_baud_div_bench;
    localparam int INT_W = 15;
    localparam int WD    = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [INT_W-1:0] div_int = '0;
    logic [2:0]       div_frac = '0;
    logic             load = 1'b0;
    logic             tick;

    always #5 clk = ~clk;

    frac_baud_div u_frac_baud_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_int (div_int),
        .div_frac(div_frac),
        .load    (load),
        .tick    (tick)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    int    meas_q[$];
    int    last_cyc = 0;
    int    ticks_n = 0;
    int    model_acc = 0;
    bit    prev_tick = 1'b0;
    bit    timed_out = 1'b0;

    function automatic void chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    task automatic do_reset();
        exp_q.delete();
        tag_q.delete();
        meas_q.delete();
        @(negedge clk);
        rst_n = 1'b0;
        load  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_acc = 0;
    endtask

    // Expected period lengths, from the 3-bit accumulate-and-carry rule.
    task automatic push_model(int n, int f, int count, string tag);
        for (int i = 0; i < count; i++) begin
            int s;
            s = model_acc + f;
            model_acc = s % 8;
            exp_q.push_back(n + s / 8);
            tag_q.push_back(tag);
        end
    endtask

    // First load from idle; the first interval is measured from the cycle
    // before the edge that samples load.
    task automatic start(int n, int f);
        @(negedge clk);
        div_int  = INT_W'(n);
        div_frac = 3'(f);
        load     = 1'b1;
        @(posedge clk);
        #1;
        last_cyc = cyc - 1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    function automatic int sum_meas(int first, int cnt);
        int s = 0;
        for (int i = first; i < first + cnt; i++) s += meas_q[i];
        return s;
    endfunction

    task automatic run_tests();
        int t0;
        // R1: no tick before any load, even with a divisor on the inputs
        do_reset();
        div_int = INT_W'(3);
        t0 = ticks_n;
        repeat (30) @(negedge clk);
        chk(ticks_n == t0, "R1 ticks before load", ticks_n - t0, 0);

        // R2 and R5: integer divisor, first period measured from the load
        do_reset();
        start(7, 0);
        push_model(7, 0, 1, "R5");
        push_model(7, 0, 5, "R2");
        drain();

        // R3, R4: fraction 3/8, the window is off the accumulator cycle
        do_reset();
        start(5, 3);
        push_model(5, 3, 16, "R3");
        drain();
        chk(sum_meas(3, 8) == 43, "R4 sum n=5 k=3", sum_meas(3, 8), 43);

        // R3, R4: fraction 7/8
        do_reset();
        start(4, 7);
        push_model(4, 7, 16, "R3");
        drain();
        chk(sum_meas(5, 8) == 39, "R4 sum n=4 k=7", sum_meas(5, 8), 39);

        // R8: zero and one are clamped to two
        do_reset();
        start(0, 0);
        push_model(2, 0, 6, "R8");
        drain();
        do_reset();
        start(1, 4);
        push_model(2, 4, 8, "R8");
        drain();
        chk(sum_meas(0, 8) == 20, "R8 sum n=1 k=4", sum_meas(0, 8), 20);

        // R9: above range clamps to 16384
        do_reset();
        start(20000, 0);
        push_model(16384, 0, 2, "R9");
        drain();

        // R6: load in mid-period, the current period keeps its length
        do_reset();
        start(10, 0);
        push_model(10, 0, 2, "R6");
        wait_tick();
        wait_tick();
        push_model(10, 0, 1, "R6");
        push_model(3, 0, 3, "R6");
        repeat (3) @(negedge clk);
        div_int = INT_W'(3);
        load    = 1'b1;
        @(negedge clk);
        load = 1'b0;
        drain();

        // R7: load during the tick cycle changes the very next period
        do_reset();
        start(6, 0);
        push_model(6, 0, 1, "R7");
        wait_tick();
        push_model(6, 0, 1, "R7");
        push_model(4, 0, 2, "R7");
        repeat (6) @(negedge clk);
        chk(tick == 1'b1, "R7 tick cycle reached", int'(tick), 1);
        div_int = INT_W'(4);
        load    = 1'b1;
        @(negedge clk);
        load = 1'b0;
        drain();

        // R11: reset mid-run stops ticks until a new load
        do_reset();
        start(3, 0);
        push_model(3, 0, 2, "R11");
        drain();
        do_reset();
        t0 = ticks_n;
        repeat (30) @(negedge clk);
        chk(ticks_n == t0, "R11 ticks after reset", ticks_n - t0, 0);
        start(4, 5);
        push_model(4, 5, 4, "R11");
        drain();
    endtask

    initial begin
        fork
            begin : monitor
                forever begin
                    @(negedge clk);
                    if (rst_n) begin
                        if (tick && prev_tick)
                            chk(1'b0, "R10 tick wider than one cycle", 2, 1);
                        if (tick) begin
                            int iv;
                            iv = cyc - last_cyc;
                            ticks_n++;
                            if (exp_q.size() > 0) begin
                                int    e;
                                string t;
                                e = exp_q.pop_front();
                                t = tag_q.pop_front();
                                chk(iv == e, {t, " period"}, iv, e);
                            end
                            meas_q.push_back(iv);
                            last_cyc = cyc;
                        end
                    end
                    prev_tick = rst_n && tick;
                end
            end
            begin : main
                run_tests();
            end
            begin : watchdog
                repeat (WD) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", WD, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule